// File: doc/BRIEF.md
# Sticky fault status register for a bridge driver

This block holds the eight-bit diagnostic word that a bridge driver offers to a host over its serial port. Three fault classes are sticky: over-temperature, thermal current reduction and current limiting. Each reads 0 once its event has been seen, and stays at 0 until the host has completed a read of the word. The enable/disable status bit is live. It is decoded every cycle from the enable and disable pins. The two diagnosis fields, one per output stage, are passed straight through from the inputs that supply them.

Every bit reads 1 when there is no fault. The word therefore shows FFh after reset on a healthy, enabled part. The serial slave pulses a capture strobe when it decodes a read instruction, and the block freezes a copy of the word at that point so the shifted byte cannot change mid-frame. At the end of the frame the slave pulses a read-done strobe, which re-arms the sticky bits whose faults have gone away.

Top module: `diag_status_reg`

## Requirements
- R1: After reset all sticky bits hold 1 and the captured copy `snap_o` equals FFh.
- R2: Word layout of `status_o`, MSB first: enable/disable status, over-temperature (`fault_i[2]`), current reduction (`fault_i[1]`), current limit (`fault_i[0]`), output-2 diagnosis `diag_i[3:2]`, output-1 diagnosis `diag_i[1:0]`.
- R3: When a bit of `fault_i` is high at a clock edge, the matching sticky bit reads 0 from that edge on.
- R4: A sticky bit at 0 stays 0 at every edge where `rd_done_i` is low, whether or not its fault is still present.
- R5: At an edge where `rd_done_i` is high and a sticky bit's fault is low, that bit returns to 1.
- R6: At an edge where both `rd_done_i` and a sticky bit's fault are high, the bit stays 0. The fault wins.
- R7: `status_o[7]` is 1 only when `en_i`=1 and `dis_i`=0, and 0 for the other three pin combinations. It follows the pins in the same cycle, with no latching.
- R8: `status_o[3:0]` equals `diag_i[3:0]` in the same cycle.
- R9: At an edge where `snap_i` is high, `snap_o` takes the value `status_o` had just before that edge. At all other edges `snap_o` holds its value.
- R10: The three sticky bits act independently. A fault or re-arm on one leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_i | input | 3 | Fault events: [2] over-temperature, [1] current reduction, [0] current limit |
| en_i | input | 1 | Enable pin level |
| dis_i | input | 1 | Disable pin level |
| diag_i | input | 4 | Diagnosis codes: [3:2] output 2, [1:0] output 1 |
| rd_done_i | input | 1 | One-cycle strobe at the end of a completed read |
| snap_i | input | 1 | One-cycle strobe at instruction decode; captures the word |
| status_o | output | 8 | Live diagnostic word |
| snap_o | output | 8 | Word captured at the last `snap_i` |

## Verification
The live fields are swept over all four enable/disable pin combinations crossed with all sixteen diagnosis codes. This separates the three "off" decodes from the single "on" one, and catches swapped or mis-ordered diagnosis bits. The sticky bits are driven through every combination of the three fault lines, the read-done strobe and the capture strobe, across successive cycles. The resulting sequences cover:
- setting a bit;
- holding it after the fault has cleared;
- re-arming it;
- the fault-beats-read collision;
- cross-talk between bits.

The capture path is checked at every cycle in which some inputs change and others stay still, so a copy that leaks the live word can be told apart from one that holds correctly.

// File: rtl/diag_reg_pkg.sv
package diag_reg_pkg;
  parameter int unsigned NUM_STICKY = 3;
  parameter int unsigned DIAG_W     = 2;
  parameter int unsigned NUM_OUT    = 2;
  localparam int unsigned DIAG_BITS = DIAG_W * NUM_OUT;
  localparam int unsigned WORD_W    = 1 + NUM_STICKY + DIAG_BITS;
  localparam logic [WORD_W-1:0] WORD_RST = '1;
endpackage

// File: rtl/diag_sticky_bit.sv
module diag_sticky_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  logic rd_i,
  output logic bit_o
);
  logic bit_q;

  // fault has priority over re-arm
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bit_q <= 1'b1;
    else if (fault_i) bit_q <= 1'b0;
    else if (rd_i)    bit_q <= 1'b1;
  end

  assign bit_o = bit_q;

  a_r3_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> !bit_o);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_o && !rd_i) |=> !bit_o);
  a_r5_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !fault_i) |=> bit_o);
  a_r6_fault_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && fault_i) |=> !bit_o);
endmodule

// File: rtl/diag_endis_dec.sv
module diag_endis_dec (
  input  logic en_i,
  input  logic dis_i,
  output logic ok_o
);
  always_comb begin
    unique case ({en_i, dis_i})
      2'b10:   ok_o = 1'b1;
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/diag_snapshot.sv
module diag_snapshot #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= '1;
    else if (cap_i) q_q <= d_i;
  end

  assign q_o = q_q;

  a_r9_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (q_o == $past(d_i)));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(q_o));
endmodule

// File: rtl/diag_status_reg.sv
module diag_status_reg
  import diag_reg_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_STICKY-1:0] fault_i,
  input  logic                  en_i,
  input  logic                  dis_i,
  input  logic [DIAG_BITS-1:0]  diag_i,
  input  logic                  rd_done_i,
  input  logic                  snap_i,
  output logic [WORD_W-1:0]     status_o,
  output logic [WORD_W-1:0]     snap_o
);
  logic [NUM_STICKY-1:0] sticky;
  logic                  run_ok;

  for (genvar g = 0; g < NUM_STICKY; g++) begin : g_sticky
    diag_sticky_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fault_i(fault_i[g]),
      .rd_i   (rd_done_i),
      .bit_o  (sticky[g])
    );
  end

  diag_endis_dec u_endis (
    .en_i (en_i),
    .dis_i(dis_i),
    .ok_o (run_ok)
  );

  assign status_o = {run_ok, sticky, diag_i};

  diag_snapshot #(.W(WORD_W)) u_snap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (snap_i),
    .d_i   (status_o),
    .q_o   (snap_o)
  );

  // R10: a bit with neither fault nor read keeps its value
  a_r10_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_i[0] && !rd_done_i) |=> (status_o[DIAG_BITS] == $past(status_o[DIAG_BITS])));
  // R7: the status bit follows the pin decode
  a_r7_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !dis_i) == status_o[WORD_W-1]);
endmodule

// File: tb/diag_status_reg_tb.sv
module diag_status_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] fault = '0;
  logic       en = 1'b1, dis = 1'b0;
  logic [3:0] diag = 4'hF;
  logic       rd = 1'b0, snap = 1'b0;
  logic [7:0] status, snapq;
  logic [2:0] lat_m = 3'b111;
  logic [7:0] snap_m = 8'hFF;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  diag_status_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fault_i(fault), .en_i(en), .dis_i(dis),
    .diag_i(diag), .rd_done_i(rd), .snap_i(snap), .status_o(status), .snap_o(snapq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_word();
    return {(en & ~dis), lat_m, diag};
  endfunction

  // one cycle: drive at negedge, check live fields, clock, check state
  task automatic cyc(logic [2:0] f, logic r, logic e, logic d, logic [3:0] dg, logic s);
    logic [7:0] pre;
    @(negedge clk);
    fault = f; rd = r; en = e; dis = d; diag = dg; snap = s;
    #1;
    check("R7 enable/disable bit", {7'b0, status[7]}, {7'b0, e & ~d});
    check("R8 diagnosis fields", {4'b0, status[3:0]}, {4'b0, dg});
    check("R2 word layout", status, exp_word());
    pre = exp_word();
    for (int b = 0; b < 3; b++) begin
      if (f[b]) lat_m[b] = 1'b0;
      else if (r) lat_m[b] = 1'b1;
    end
    if (s) snap_m = pre;
    @(posedge clk);
    #1;
    for (int b = 0; b < 3; b++) begin
      if (f[b] && r)  check("R6 fault beats read", {7'b0, status[4+b]}, {7'b0, lat_m[b]});
      else if (f[b])  check("R3 fault sets", {7'b0, status[4+b]}, {7'b0, lat_m[b]});
      else if (r)     check("R5 read re-arms", {7'b0, status[4+b]}, {7'b0, lat_m[b]});
      else            check("R4 sticky hold", {7'b0, status[4+b]}, {7'b0, lat_m[b]});
    end
    check("R10 independent sticky bits", {5'b0, status[6:4]}, {5'b0, lat_m});
    check("R9 captured word", snapq, snap_m);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #10;
    check("R1 reset snapshot", snapq, 8'hFF);
    check("R1 reset sticky bits", status, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    // live fields: all pin and diagnosis combinations, capture every other
    for (int i = 0; i < 64; i++)
      cyc(3'b000, 1'b0, i[5], i[4], i[3:0], i[0]);
    // sticky: every fault/read/capture combination, twice through
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < 32; i++)
        cyc(i[2:0], i[3], 1'b1, 1'b0, 4'hA ^ i[3:0], i[4]);
    // set one bit, let its fault go, hold, then re-arm
    for (int b = 0; b < 3; b++) begin
      cyc(3'b000, 1'b1, 1'b1, 1'b0, 4'h5, 1'b0);
      cyc(3'b001 << b, 1'b0, 1'b1, 1'b0, 4'h5, 1'b0);
      cyc(3'b000, 1'b0, 1'b1, 1'b0, 4'h5, 1'b1);
      cyc(3'b000, 1'b0, 1'b0, 1'b1, 4'h3, 1'b0);
      cyc(3'b001 << b, 1'b1, 1'b1, 1'b0, 4'h5, 1'b0);
      cyc(3'b000, 1'b1, 1'b1, 1'b0, 4'h5, 1'b1);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule